// File: doc/BRIEF.md
# Nonvolatile Write Commit Gate and Busy Timer

This block sits behind a serial-bus slave front end and decides, when a write transaction ends, whether the bytes just received should be burned into nonvolatile storage. The front end reports transaction events to it: a start, a stop, a level saying a byte is partly shifted in, and a pulse for each completed data byte with its acknowledge, data value, word address and target (main array or register bank). The block collects these events for the current transaction. When the stop arrives, it checks how the stop was timed, whether any byte hit a write-protected array block, whether the register bank has been unlocked, and whether a real-time-clock section write was a full page.

When a write is accepted, the block emits a single-cycle commit pulse and enters a busy period of a fixed, parameterized number of cycles that stands in for the internal programming time. While busy, it ignores every front-end event and raises an acknowledge-inhibit flag, so the front end releases the data line and answers no address byte. A master polls for completion by repeatedly addressing the device until an acknowledge comes back. The storage array itself is outside this block.

Top module: `nvw_gate_ctrl`

## Requirements
- R1: After reset, commit, busy and ack_inhibit are low and the register bank is locked.
- R2: A stop, with in_byte low, that follows at least one data byte reported with data_acked high produces exactly one commit pulse in the cycle after the stop is sampled, for an array target (tgt=0) with no protected byte.
- R3: A stop that arrives while in_byte is high, or before any acknowledged data byte, starts no write and clears the transaction, so a later stop alone does not commit.
- R4: busy and ack_inhibit rise together with commit and stay high for exactly WCYC cycles.
- R5: While busy is high, start, stop and data events are ignored; no commit occurs and no bytes from that time are counted.
- R6: The array is split into NBLK equal blocks selected by address bits [ARR_BITS-1 -: log2(NBLK)]; an array write in which any byte falls in a block whose wp_blocks bit is set does not commit, and busy stays low.
- R7: A register-bank write (tgt=1) outside the status register commits only after the unlock sequence: a status-register write (address SR_ADDR, default 3Fh) of 02h, then a separate status-register write of 06h.
- R8: Any status-register write of a value other than 02h or 06h, or 06h without a preceding 02h, leaves the register bank locked; 02h always restarts the sequence.
- R9: A status-register write never produces a commit.
- R10: A register-bank write whose first address lies in the clock section (RTC_BASE to RTC_BASE+7, default 30h) commits only with at least 8 acknowledged data bytes.
- R11: A data byte reported with data_acked low is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| in_byte | input | 1 | High while a byte is partly shifted in |
| ev_data | input | 1 | A write data byte finished (one-cycle pulse) |
| data_acked | input | 1 | The finished data byte was acknowledged |
| data_byte | input | 8 | Value of the finished data byte |
| tgt | input | 1 | Target of the byte: 0 array, 1 register bank |
| addr | input | 16 | Word address the byte lands at |
| wp_blocks | input | NBLK | Per-block write protection of the array |
| commit | output | 1 | One-cycle pulse: start the internal write |
| busy | output | 1 | Internal write cycle in progress |
| ack_inhibit | output | 1 | Front end must not acknowledge or drive the bus |

## Verification
The commit decision is driven with single-byte and multi-byte array writes, stops placed before any byte, mid-byte and after a non-acknowledged byte, and events fired during the busy window; these separate a correct byte-and-ACK count and input gating from a decision that merely reacts to any stop. Protected and unprotected blocks distinguish the protection lookup from the address decode. Register-bank writes are tried locked, after a reversed unlock order, after the proper 02h-06h sequence and after a re-lock, and clock-section writes of seven and eight bytes show the page-length rule apart from the unlock rule.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    localparam int NVW_ADDR_W = 16;
    localparam int NVW_DATA_W = 8;
    localparam int NVW_CNT_W  = 5;

    localparam logic [NVW_DATA_W-1:0] UNLOCK_STEP1 = 8'h02;
    localparam logic [NVW_DATA_W-1:0] UNLOCK_STEP2 = 8'h06;

    typedef enum logic {
        TGT_ARRAY = 1'b0,
        TGT_REGS  = 1'b1
    } nvw_tgt_e;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_HALF   = 2'd1,
        UL_OPEN   = 2'd2
    } nvw_unlock_e;

    typedef struct packed {
        logic [NVW_CNT_W-1:0]  nbytes;
        logic [NVW_ADDR_W-1:0] first_addr;
        logic [NVW_DATA_W-1:0] first_data;
        nvw_tgt_e              tgt;
        logic                  prot_hit;
    } nvw_txn_t;

    function automatic logic [NVW_CNT_W-1:0] sat_inc(input logic [NVW_CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    function automatic nvw_unlock_e unlock_next(input nvw_unlock_e cur,
                                                input logic [NVW_DATA_W-1:0] val);
        if (val == UNLOCK_STEP1)
            return UL_HALF;
        else if (val == UNLOCK_STEP2 && cur != UL_LOCKED)
            return UL_OPEN;
        else
            return UL_LOCKED;
    endfunction

endpackage

// File: rtl/nvw_txn_track.sv
module nvw_txn_track
    import nvw_pkg::*;
#(
    parameter int ARR_BITS = 12,
    parameter int NBLK     = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  stop,
    input  logic                  data_ev,
    input  logic                  data_acked,
    input  logic [NVW_DATA_W-1:0] data_byte,
    input  nvw_tgt_e              tgt,
    input  logic [NVW_ADDR_W-1:0] addr,
    input  logic [NBLK-1:0]       wp_blocks,
    output nvw_txn_t              txn
);
    localparam int BLK_BITS = $clog2(NBLK);

    logic [BLK_BITS-1:0] blk_idx;
    logic                byte_prot;

    assign blk_idx   = addr[ARR_BITS-1 -: BLK_BITS];
    assign byte_prot = (tgt == TGT_ARRAY) && wp_blocks[blk_idx];

    always_ff @(posedge clk) begin
        if (rst || start || stop) begin
            txn <= '0;
        end else if (data_ev && data_acked) begin
            if (txn.nbytes == '0) begin
                txn.first_addr <= addr;
                txn.first_data <= data_byte;
                txn.tgt        <= tgt;
            end
            txn.nbytes   <= sat_inc(txn.nbytes);
            txn.prot_hit <= txn.prot_hit | byte_prot;
        end
    end

endmodule

// File: rtl/nvw_unlock.sv
module nvw_unlock
    import nvw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sr_wr,
    input  logic [NVW_DATA_W-1:0] sr_val,
    output logic                  is_open
);
    nvw_unlock_e state;

    always_ff @(posedge clk) begin
        if (rst)
            state <= UL_LOCKED;
        else if (sr_wr)
            state <= unlock_next(state, sr_val);
    end

    assign is_open = (state == UL_OPEN);

endmodule

// File: rtl/nvw_busy_timer.sv
module nvw_busy_timer #(
    parameter int WCYC = 600000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    localparam int TIMER_W = $clog2(WCYC + 1);

    logic [TIMER_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            busy   <= 1'b0;
        end else if (load) begin
            remain <= TIMER_W'(WCYC);
            busy   <= 1'b1;
        end else if (busy) begin
            if (remain == TIMER_W'(1))
                busy <= 1'b0;
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/nvw_gate_ctrl.sv
module nvw_gate_ctrl
    import nvw_pkg::*;
#(
    parameter int WCYC     = 600000,
    parameter int ARR_BITS = 12,
    parameter int NBLK     = 4,
    parameter int SR_ADDR  = 'h3F,
    parameter int RTC_BASE = 'h30,
    parameter int RTC_LEN  = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ev_start,
    input  logic                  ev_stop,
    input  logic                  in_byte,
    input  logic                  ev_data,
    input  logic                  data_acked,
    input  logic [NVW_DATA_W-1:0] data_byte,
    input  logic                  tgt,
    input  logic [NVW_ADDR_W-1:0] addr,
    input  logic [NBLK-1:0]       wp_blocks,
    output logic                  commit,
    output logic                  busy,
    output logic                  ack_inhibit
);
    localparam logic [NVW_ADDR_W-1:0] SR_A    = NVW_ADDR_W'(SR_ADDR);
    localparam logic [NVW_ADDR_W-1:0] RTC_LO  = NVW_ADDR_W'(RTC_BASE);
    localparam logic [NVW_ADDR_W-1:0] RTC_HI  = NVW_ADDR_W'(RTC_BASE + RTC_LEN);
    localparam logic [NVW_CNT_W-1:0]  RTC_CNT = NVW_CNT_W'(RTC_LEN);

    nvw_txn_t txn;
    logic     g_start, g_stop, g_data;
    logic     stop_ok, is_status, in_rtc, regs_ok, commit_req, sr_wr, unl_open;

    // every front-end event is dropped while the internal write runs
    assign g_start = ev_start & ~busy;
    assign g_stop  = ev_stop  & ~busy;
    assign g_data  = ev_data  & ~busy;

    nvw_txn_track #(.ARR_BITS(ARR_BITS), .NBLK(NBLK)) u_track (
        .clk        (clk),
        .rst        (rst),
        .start      (g_start),
        .stop       (g_stop),
        .data_ev    (g_data),
        .data_acked (data_acked),
        .data_byte  (data_byte),
        .tgt        (nvw_tgt_e'(tgt)),
        .addr       (addr),
        .wp_blocks  (wp_blocks),
        .txn        (txn)
    );

    assign stop_ok   = g_stop && !in_byte && (txn.nbytes != '0);
    assign is_status = (txn.tgt == TGT_REGS) && (txn.first_addr == SR_A);
    assign in_rtc    = (txn.tgt == TGT_REGS) && (txn.first_addr >= RTC_LO)
                       && (txn.first_addr < RTC_HI);
    assign regs_ok   = !is_status && unl_open && (!in_rtc || txn.nbytes >= RTC_CNT);
    assign sr_wr     = stop_ok && is_status;

    always_comb begin
        commit_req = 1'b0;
        if (stop_ok) begin
            if (txn.tgt == TGT_ARRAY)
                commit_req = !txn.prot_hit;
            else
                commit_req = regs_ok;
        end
    end

    nvw_unlock u_unlock (
        .clk     (clk),
        .rst     (rst),
        .sr_wr   (sr_wr),
        .sr_val  (txn.first_data),
        .is_open (unl_open)
    );

    nvw_busy_timer #(.WCYC(WCYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (commit_req),
        .busy (busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            commit <= 1'b0;
        else
            commit <= commit_req;
    end

    assign ack_inhibit = busy;

endmodule

// File: rtl/nvw_gate_ctrl_chk.sv
module nvw_gate_ctrl_chk #(
    parameter int WCYC = 600000
) (
    input logic clk,
    input logic rst,
    input logic ev_stop,
    input logic in_byte,
    input logic commit,
    input logic busy,
    input logic ack_inhibit
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= 0;
        else if (busy)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    // R4: busy window length measured by counter
    always_ff @(posedge clk) begin
        if (!rst && !busy && run_len != 0)
            p_busy_len_r4: assert (run_len == WCYC);
    end

    p_commit_single_r2: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);

    p_commit_after_stop_r2: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(ev_stop));

    p_midbyte_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && in_byte) |=> !commit);

    p_commit_busy_r4: assert property (@(posedge clk) disable iff (rst)
        commit |-> (busy && ack_inhibit));

    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        busy |=> !commit);

endmodule

bind nvw_gate_ctrl nvw_gate_ctrl_chk #(.WCYC(WCYC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev_stop     (ev_stop),
    .in_byte     (in_byte),
    .commit      (commit),
    .busy        (busy),
    .ack_inhibit (ack_inhibit)
);

// File: tb/nvw_gate_ctrl_bench.sv
module nvw_gate_ctrl_bench;
    localparam int WCYC = 40;
    localparam int NBLK = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ev_start = 0, ev_stop = 0, in_byte = 0, ev_data = 0, data_acked = 0;
    logic [7:0]  data_byte = 0;
    logic        tgt = 0;
    logic [15:0] addr = 0;
    logic [NBLK-1:0] wp_blocks = 0;
    logic        commit, busy, ack_inhibit;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    nvw_gate_ctrl #(.WCYC(WCYC), .NBLK(NBLK)) u_nvw_gate_ctrl (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .in_byte(in_byte), .ev_data(ev_data), .data_acked(data_acked),
        .data_byte(data_byte), .tgt(tgt), .addr(addr), .wp_blocks(wp_blocks),
        .commit(commit), .busy(busy), .ack_inhibit(ack_inhibit)
    );

    task automatic chk(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_start();
        ev_start = 1; @(negedge clk); ev_start = 0;
    endtask

    task automatic do_byte(input logic t, input logic [15:0] a,
                           input logic [7:0] d, input logic ack);
        ev_data = 1; tgt = t; addr = a; data_byte = d; data_acked = ack;
        @(negedge clk);
        ev_data = 0; data_acked = 0;
    endtask

    // stop, then check commit result and, if committed, busy length
    task automatic do_stop(input int exp, string req);
        int n;
        ev_stop = 1; @(negedge clk); ev_stop = 0;
        chk(req, commit, exp, "commit after stop");
        chk(req, busy, exp, "busy after stop");
        if (exp != 0) begin
            n = 0;
            while (busy && n < 10 * WCYC) begin
                chk("R4", ack_inhibit, 1, "ack_inhibit while busy");
                n++;
                @(negedge clk);
            end
            chk("R4", n, WCYC, "busy length");
            chk("R4", ack_inhibit, 0, "ack_inhibit after busy");
        end else begin
            @(negedge clk);
            chk(req, ack_inhibit, 0, "ack_inhibit stays low");
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d, input int nb,
                             input int exp, string req);
        do_start();
        for (int i = 0; i < nb; i++) do_byte(1'b1, a + 16'(i), d, 1'b1);
        do_stop(exp, req);
    endtask

    task automatic t_reset();
        chk("R1", commit, 0, "commit at reset");
        chk("R1", busy, 0, "busy at reset");
        chk("R1", ack_inhibit, 0, "ack_inhibit at reset");
        reg_write(16'h0010, 8'h55, 1, 0, "R1"); // locked after reset
    endtask

    task automatic t_array_write();
        do_start(); do_byte(1'b0, 16'h0123, 8'hA5, 1'b1); do_stop(1, "R2");
        do_start();
        for (int i = 0; i < 3; i++) do_byte(1'b0, 16'h0200 + 16'(i), 8'(i), 1'b1);
        do_stop(1, "R2");
    endtask

    task automatic t_bad_stops();
        do_start(); do_stop(0, "R3");                        // no data byte
        do_start(); do_byte(1'b0, 16'h0010, 8'h11, 1'b1);
        in_byte = 1; do_stop(0, "R3"); in_byte = 0;          // mid-byte stop
        do_stop(0, "R3");                                    // transaction was cleared
        do_start(); do_byte(1'b0, 16'h0010, 8'h11, 1'b0);
        do_stop(0, "R11");                                   // unacked byte
    endtask

    task automatic t_busy_ignore();
        ev_start = 1; @(negedge clk); ev_start = 0;
        do_byte(1'b0, 16'h0040, 8'h01, 1'b1);
        ev_stop = 1; @(negedge clk); ev_stop = 0;
        chk("R2", commit, 1, "commit before busy test");
        do_start(); do_byte(1'b0, 16'h0041, 8'h02, 1'b1);
        ev_stop = 1; @(negedge clk); ev_stop = 0;
        chk("R5", commit, 0, "no commit during busy");
        chk("R5", busy, 1, "busy held");
        while (busy) @(negedge clk);
        do_stop(0, "R5");                                    // bytes during busy not counted
    endtask

    task automatic t_protect();
        wp_blocks = 4'b0100;                                  // block 2: 800h-BFFh
        do_start(); do_byte(1'b0, 16'h0805, 8'h77, 1'b1); do_stop(0, "R6");
        do_start(); do_byte(1'b0, 16'h0405, 8'h77, 1'b1);
        do_byte(1'b0, 16'h0A00, 8'h78, 1'b1); do_stop(0, "R6");
        do_start(); do_byte(1'b0, 16'h0405, 8'h77, 1'b1); do_stop(1, "R6");
        wp_blocks = '0;
    endtask

    task automatic t_unlock();
        reg_write(16'h003F, 8'h06, 1, 0, "R9");
        reg_write(16'h003F, 8'h02, 1, 0, "R9");
        reg_write(16'h0010, 8'h33, 1, 0, "R8");              // only half open
        reg_write(16'h003F, 8'h06, 1, 0, "R9");
        reg_write(16'h0010, 8'h33, 1, 1, "R7");              // open
        reg_write(16'h0011, 8'h34, 2, 1, "R7");              // stays open
    endtask

    task automatic t_rtc();
        reg_write(16'h0030, 8'h12, 7, 0, "R10");
        reg_write(16'h0030, 8'h12, 8, 1, "R10");
        reg_write(16'h0034, 8'h12, 8, 1, "R10");
        reg_write(16'h003F, 8'h00, 1, 0, "R9");              // re-lock
        reg_write(16'h0010, 8'h33, 1, 0, "R8");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_array_write();
        t_bad_stops();
        t_busy_ignore();
        t_protect();
        t_unlock();
        t_rtc();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule